// File: doc/BRIEF.md
# Luma/Chroma Brush Store Loader

This block turns a stream of bytes coming off a disk into picture samples for a pair of 256-wide image stores. One store holds luma and the other holds chroma. Bytes arrive in pairs. The first byte of a pair is held as luma. The second byte is taken as chroma and causes one store write, placed at an address built from two position counters. Each position offset is scrambled by an exclusive-or with 7.

The loader also tracks picture lines. A line ends under either of two conditions:
- the horizontal counter runs past the top of its range, or
- a fixed number of bytes has arrived since the line began.

Every line end reloads the horizontal counter, bumps the vertical counter, counts the line and toggles a line clock. The line count drives a disk side switch part way through the read, and a final line ends the read. The read also ends when the vertical counter runs out of range.

A start pulse loads the two start positions and arms the loader. Bytes are accepted only while it is armed.

Top module: `brush_store_loader`

## Requirements
- R1: After reset, every output is 0 and the loader is idle.
- R2: A byte strobe has no effect while the loader is idle: before the first start pulse, and after loadDone has risen. No store write occurs and lineCount, lineClk and diskSide keep their values.
- R3: After a start, bytes alternate between two roles, beginning with luma. A luma byte is only held. The chroma byte that follows causes a write, one cycle after that byte is strobed. The luma port then carries the held luma byte and the chroma port carries the chroma byte.
- R4: Both ports write to the same address, {yOff, xOff}, with yOff in bits 15:8 and xOff in bits 7:0. Here xOff = ((xCnt − xStart) XOR 7) mod 256 and yOff = ((yCnt − yStart) XOR 7) mod 256, using the counter values before this sample's increment.
- R5: lumaWe pulses only if lumaEn is 1 at the chroma byte, and chromaWe pulses only if chromaEn is 1 at that byte. The two enables act independently.
- R6: xCnt starts at xStart and goes up by one per sample. The sample that brings xCnt to 4096 ends the line.
- R7: A byte counter counts every accepted byte of a line. The byte that brings it to 768 ends the line.
- R8: If one byte meets both line-end conditions, only one line end occurs. The byte counter restarts at 1, so that byte counts toward the new line.
- R9: Each line end does all of the following:
  - reloads xCnt with xStart;
  - increments yCnt;
  - increments lineCount;
  - inverts lineClk.
- R10: The line end that brings yCnt to 4096 raises loadDone.
- R11: On side 0, the line end that brings lineCount to 13 sets diskSide to 1.
- R12: On side 1, the line end that brings lineCount to 25 raises loadDone.
- R13: A start pulse has these effects, and takes priority over a byte strobed in the same cycle:
  - clears lineCount, lineClk, diskSide, loadDone and the byte counter;
  - makes the next byte a luma byte;
  - loads xStart and yStart into the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Arms the loader and loads the start positions |
| xStart | input | 12 | Horizontal start position |
| yStart | input | 12 | Vertical start position |
| lumaEn | input | 1 | Enables writes to the luma store |
| chromaEn | input | 1 | Enables writes to the chroma store |
| byteValid | input | 1 | Disk byte strobe |
| byteData | input | 8 | Disk byte |
| lumaWe | output | 1 | Luma store write strobe |
| lumaAddr | output | 16 | Luma store address |
| lumaData | output | 8 | Luma store write data |
| chromaWe | output | 1 | Chroma store write strobe |
| chromaAddr | output | 16 | Chroma store address |
| chromaData | output | 8 | Chroma store write data |
| lineCount | output | 16 | Lines completed since start |
| lineClk | output | 1 | Toggles at each line end |
| diskSide | output | 1 | Disk side being read |
| loadDone | output | 1 | Read finished |

## Verification
The bench aims at the byte where the horizontal wrap and the 768-byte limit land together. A design that honours both conditions there counts two lines. A design that clears the byte counter to 0 instead of 1 ends every later line one byte late.

Short lines drive the read past line 13 and on to line 25. This catches a side switch or a finish that is off by one line, and a finish that fails to stop later writes.

Start pulses arrive in mid pair and in mid line. A loader that keeps its role toggle would swap luma and chroma, and one that keeps its byte counter would end the next line early.

A vertical start near the top of the range checks the early finish.

// File: rtl/brush_ldr_pkg.sv
package brush_ldr_pkg;
  typedef struct packed {
    logic load;
    logic latchLuma;
    logic writeSample;
    logic advance;
  } ldrStrobe_t;
endpackage

// File: rtl/brush_ldr_ctrl.sv
module brush_ldr_ctrl
  import brush_ldr_pkg::*;
#(
  parameter int LINE_BYTES = 768,
  parameter int SIDE_LINES = 13,
  parameter int LAST_LINES = 25,
  parameter int LCNT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              byteValid,
  input  logic              xAtLast,
  input  logic              yAtLast,
  input  logic [LCNT_W-1:0] lineCount,
  output ldrStrobe_t        ctl,
  output logic              loadDone,
  output logic              diskSide
);
  localparam int LEN_W = $clog2(LINE_BYTES + 1);

  logic             active;
  logic             expectLuma;
  logic [LEN_W-1:0] lineLen;
  logic             accept;
  logic             xWrap;
  logic             lenHit;
  logic [LCNT_W-1:0] nextCount;

  always_comb begin
    accept          = active & byteValid & ~startPulse;
    ctl.load        = startPulse;
    ctl.latchLuma   = accept & expectLuma;
    ctl.writeSample = accept & ~expectLuma;
    xWrap           = ctl.writeSample & xAtLast;
    lenHit          = accept & ~xWrap & (lineLen == LEN_W'(LINE_BYTES - 1));
    ctl.advance     = xWrap | lenHit;
    nextCount       = lineCount + LCNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      expectLuma <= 1'b1;
      lineLen    <= '0;
      loadDone   <= 1'b0;
      diskSide   <= 1'b0;
    end else if (startPulse) begin
      active     <= 1'b1;
      expectLuma <= 1'b1;
      lineLen    <= '0;
      loadDone   <= 1'b0;
      diskSide   <= 1'b0;
    end else if (accept) begin
      expectLuma <= ~expectLuma;
      if (xWrap)       lineLen <= LEN_W'(1);
      else if (lenHit) lineLen <= '0;
      else             lineLen <= lineLen + LEN_W'(1);
      if (ctl.advance) begin
        if (yAtLast) begin
          loadDone <= 1'b1;
          active   <= 1'b0;
        end
        if (!diskSide && nextCount == LCNT_W'(SIDE_LINES)) begin
          diskSide <= 1'b1;
        end else if (diskSide && nextCount == LCNT_W'(LAST_LINES)) begin
          loadDone <= 1'b1;
          active   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/brush_ldr_dp.sv
module brush_ldr_dp
  import brush_ldr_pkg::*;
#(
  parameter int START_W = 12,
  parameter int COORD_W = 8,
  parameter int LCNT_W  = 16,
  localparam int CNT_W  = START_W + 1,
  localparam int ADDR_W = 2 * COORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ldrStrobe_t         ctl,
  input  logic [START_W-1:0] xStart,
  input  logic [START_W-1:0] yStart,
  input  logic               lumaEn,
  input  logic               chromaEn,
  input  logic [7:0]         byteData,
  output logic               xAtLast,
  output logic               yAtLast,
  output logic               lumaWe,
  output logic               chromaWe,
  output logic [ADDR_W-1:0]  storeAddr,
  output logic [7:0]         lumaData,
  output logic [7:0]         chromaData,
  output logic [LCNT_W-1:0]  lineCount,
  output logic               lineClk
);
  localparam logic [CNT_W-1:0] LAST_POS = {1'b0, {START_W{1'b1}}};

  logic [CNT_W-1:0]   xCnt;
  logic [CNT_W-1:0]   yCnt;
  logic [START_W-1:0] xBase;
  logic [START_W-1:0] yBase;
  logic [7:0]         lumaHold;
  logic [COORD_W-1:0] xOff;
  logic [COORD_W-1:0] yOff;

  always_comb begin
    xAtLast = (xCnt == LAST_POS);
    yAtLast = (yCnt == LAST_POS);
    xOff = (xCnt[COORD_W-1:0] - xBase[COORD_W-1:0]) ^ COORD_W'(7);
    yOff = (yCnt[COORD_W-1:0] - yBase[COORD_W-1:0]) ^ COORD_W'(7);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xCnt       <= '0;
      yCnt       <= '0;
      xBase      <= '0;
      yBase      <= '0;
      lumaHold   <= '0;
      lumaWe     <= 1'b0;
      chromaWe   <= 1'b0;
      storeAddr  <= '0;
      lumaData   <= '0;
      chromaData <= '0;
      lineCount  <= '0;
      lineClk    <= 1'b0;
    end else begin
      lumaWe   <= 1'b0;
      chromaWe <= 1'b0;
      if (ctl.load) begin
        xCnt      <= CNT_W'(xStart);
        yCnt      <= CNT_W'(yStart);
        xBase     <= xStart;
        yBase     <= yStart;
        lineCount <= '0;
        lineClk   <= 1'b0;
      end else begin
        if (ctl.latchLuma) lumaHold <= byteData;
        if (ctl.writeSample) begin
          lumaWe     <= lumaEn;
          chromaWe   <= chromaEn;
          storeAddr  <= {yOff, xOff};
          lumaData   <= lumaHold;
          chromaData <= byteData;
        end
        if (ctl.advance) begin
          xCnt      <= CNT_W'(xBase);
          yCnt      <= yCnt + CNT_W'(1);
          lineCount <= lineCount + LCNT_W'(1);
          lineClk   <= ~lineClk;
        end else if (ctl.writeSample) begin
          xCnt <= xCnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/brush_store_loader.sv
module brush_store_loader
  import brush_ldr_pkg::*;
#(
  parameter int START_W    = 12,
  parameter int COORD_W    = 8,
  parameter int LCNT_W     = 16,
  parameter int LINE_BYTES = 768,
  parameter int SIDE_LINES = 13,
  parameter int LAST_LINES = 25,
  localparam int ADDR_W    = 2 * COORD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [START_W-1:0] xStart,
  input  logic [START_W-1:0] yStart,
  input  logic               lumaEn,
  input  logic               chromaEn,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  output logic               lumaWe,
  output logic [ADDR_W-1:0]  lumaAddr,
  output logic [7:0]         lumaData,
  output logic               chromaWe,
  output logic [ADDR_W-1:0]  chromaAddr,
  output logic [7:0]         chromaData,
  output logic [LCNT_W-1:0]  lineCount,
  output logic               lineClk,
  output logic               diskSide,
  output logic               loadDone
);
  ldrStrobe_t        ctl;
  logic              xAtLast;
  logic              yAtLast;
  logic [ADDR_W-1:0] storeAddr;

  brush_ldr_ctrl #(
    .LINE_BYTES(LINE_BYTES), .SIDE_LINES(SIDE_LINES),
    .LAST_LINES(LAST_LINES), .LCNT_W(LCNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
    .xAtLast(xAtLast), .yAtLast(yAtLast), .lineCount(lineCount),
    .ctl(ctl), .loadDone(loadDone), .diskSide(diskSide)
  );

  brush_ldr_dp #(
    .START_W(START_W), .COORD_W(COORD_W), .LCNT_W(LCNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .xStart(xStart), .yStart(yStart),
    .lumaEn(lumaEn), .chromaEn(chromaEn), .byteData(byteData),
    .xAtLast(xAtLast), .yAtLast(yAtLast), .lumaWe(lumaWe), .chromaWe(chromaWe),
    .storeAddr(storeAddr), .lumaData(lumaData), .chromaData(chromaData),
    .lineCount(lineCount), .lineClk(lineClk)
  );

  assign lumaAddr   = storeAddr;
  assign chromaAddr = storeAddr;
endmodule

// File: rtl/brush_store_loader_chk.sv
module brush_store_loader_chk #(
  parameter int LCNT_W     = 16,
  parameter int SIDE_LINES = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              byteValid,
  input logic              lumaWe,
  input logic              chromaWe,
  input logic [LCNT_W-1:0] lineCount,
  input logic              lineClk,
  input logic              diskSide,
  input logic              loadDone
);
  // R3
  write_follows_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lumaWe || chromaWe) |-> $past(byteValid));

  // R9
  clk_tracks_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(startPulse) && lineCount != $past(lineCount)) |-> lineClk != $past(lineClk));

  // R13
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (lineCount == '0 && !lineClk && !diskSide && !loadDone));

  // R12
  done_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && !startPulse) |=> loadDone);

  // R2
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && $past(loadDone)) |-> !(lumaWe || chromaWe));

  // R11
  side_switch_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(diskSide) |-> lineCount == LCNT_W'(SIDE_LINES));
endmodule

bind brush_store_loader brush_store_loader_chk #(
  .LCNT_W(LCNT_W), .SIDE_LINES(SIDE_LINES)
) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteValid(byteValid),
  .lumaWe(lumaWe), .chromaWe(chromaWe), .lineCount(lineCount),
  .lineClk(lineClk), .diskSide(diskSide), .loadDone(loadDone)
);

// File: tb/brush_store_loader_tb.sv
`timescale 1ns/1ps
module brush_store_loader_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [11:0] xStart = '0;
  logic [11:0] yStart = '0;
  logic        lumaEn = 1'b0;
  logic        chromaEn = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        lumaWe, chromaWe, lineClk, diskSide, loadDone;
  logic [15:0] lumaAddr, chromaAddr, lineCount;
  logic [7:0]  lumaData, chromaData;

  brush_store_loader u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .xStart(xStart),
    .yStart(yStart), .lumaEn(lumaEn), .chromaEn(chromaEn),
    .byteValid(byteValid), .byteData(byteData), .lumaWe(lumaWe),
    .lumaAddr(lumaAddr), .lumaData(lumaData), .chromaWe(chromaWe),
    .chromaAddr(chromaAddr), .chromaData(chromaData), .lineCount(lineCount),
    .lineClk(lineClk), .diskSide(diskSide), .loadDone(loadDone)
  );

  always #2.5 clk = ~clk;

  int    nChecks = 0;
  int    nFails  = 0;
  string curTag  = "R1";
  bit    finished = 1'b0;

  // model state
  int mX, mY, mXs, mYs, mLen, mCnt;
  bit mClk, mSide, mDone, mActive, mLuma, mLWe, mCWe;
  int mAddr, mHold, mLData, mCData;

  task automatic check(input string what, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", curTag, what, got, exp);
    end
  endtask

  task automatic modelStart(input int xs, input int ys);
    mXs = xs; mYs = ys; mX = xs; mY = ys;
    mLen = 0; mCnt = 0; mClk = 0; mSide = 0; mDone = 0; mActive = 1; mLuma = 1;
  endtask

  task automatic modelByte(input int d, input bit le, input bit ce);
    bit xw, adv;
    mLWe = 0; mCWe = 0; xw = 0; adv = 0;
    if (!mActive) return;
    if (mLuma) begin
      mHold = d; mLuma = 0;
    end else begin
      mLWe = le; mCWe = ce;
      mAddr = ((((mY - mYs) ^ 7) & 255) << 8) | (((mX - mXs) ^ 7) & 255);
      mLData = mHold; mCData = d;
      mX++; mLuma = 1;
      if (mX == 4096) xw = 1;
    end
    if (xw) begin adv = 1; mLen = 1; end
    else begin
      mLen++;
      if (mLen == 768) begin adv = 1; mLen = 0; end
    end
    if (adv) begin
      mX = mXs; mY++; mCnt++; mClk = ~mClk;
      if (mY == 4096) begin mDone = 1; mActive = 0; end
      if (!mSide && mCnt == 13) mSide = 1;
      else if (mSide && mCnt == 25) begin mDone = 1; mActive = 0; end
    end
  endtask

  task automatic checkState();
    check("R9 lineCount", int'(lineCount), mCnt);
    check("R9 lineClk", int'(lineClk), int'(mClk));
    check("R11 diskSide", int'(diskSide), int'(mSide));
    check("R10 R12 loadDone", int'(loadDone), int'(mDone));
  endtask

  task automatic pushByte(input int d, input bit le, input bit ce);
    lumaEn = le; chromaEn = ce; byteData = 8'(d); byteValid = 1'b1;
    modelByte(d, le, ce);
    @(posedge clk); #1;
    byteValid = 1'b0;
    check("R5 lumaWe", int'(lumaWe), int'(mLWe));
    check("R5 chromaWe", int'(chromaWe), int'(mCWe));
    if (mLWe || mCWe) begin
      check("R4 lumaAddr", int'(lumaAddr), mAddr);
      check("R4 chromaAddr", int'(chromaAddr), mAddr);
      check("R3 lumaData", int'(lumaData), mLData);
      check("R3 chromaData", int'(chromaData), mCData);
    end
    checkState();
  endtask

  task automatic randBytes(input int n);
    for (int i = 0; i < n; i++)
      pushByte(int'($urandom() & 255), 1'($urandom()), 1'($urandom()));
  endtask

  task automatic startLoad(input int xs, input int ys);
    xStart = 12'(xs); yStart = 12'(ys); startPulse = 1'b1;
    byteValid = 1'b1; byteData = 8'h5A;  // must be ignored (R13)
    modelStart(xs, ys);
    @(posedge clk); #1;
    startPulse = 1'b0; byteValid = 1'b0;
    curTag = "R13";
    checkState();
  endtask

  initial begin
    void'($urandom(32'hB5E1));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    check("R1 lumaWe", int'(lumaWe), 0);
    check("R1 chromaWe", int'(chromaWe), 0);
    check("R1 lineCount", int'(lineCount), 0);
    check("R1 flags", int'({lineClk, diskSide, loadDone}), 0);
    check("R1 addr", int'(lumaAddr), 0);
    mActive = 0; mCnt = 0; mClk = 0; mSide = 0; mDone = 0;

    curTag = "R2"; randBytes(4);                 // idle before start
    startLoad(12'hFF0, 12'h010); curTag = "R6"; randBytes(100);
    startLoad(12'h000, 12'h020); curTag = "R7"; randBytes(1546);
    startLoad(12'hE80, 12'h005); curTag = "R8"; randBytes(1600);
    // R8: the shared byte counts toward the next line, so the second line ends by length
    check("R8 lines", int'(lineCount), 2);
    startLoad(12'hFF8, 12'h000); curTag = "R11"; randBytes(208);
    check("R11 side after 13 lines", int'(diskSide), 1);
    curTag = "R12"; randBytes(192);
    check("R12 done after 25 lines", int'(loadDone), 1);
    curTag = "R2"; randBytes(10);                // ignored after finish
    check("R2 lineCount frozen", int'(lineCount), 25);
    startLoad(12'hFFC, 12'hFFD); curTag = "R10"; randBytes(30);
    check("R10 done at y wrap", int'(loadDone), 1);
    startLoad(12'hFF0, 12'h000); curTag = "R13"; randBytes(37);
    startLoad(12'hFF4, 12'h100); randBytes(40);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule